// File: doc/BRIEF.md
# Dual-Pipe In-Order Issue Steering

This block is the issue stage of a small in-order vector core. Each cycle it holds up to two decoded instructions in program order: an older slot and a younger slot. Every instruction carries a class code, and the class alone fixes which of the two execution pipes runs it. The even pipe takes multiplies, fixed-point arithmetic, logical work and word shifts. The odd pipe takes permutes, rotates, branches, local-store traffic and channel operations.

The stage sends both held instructions in the same cycle only when the older one goes to the even pipe, the younger one goes to the odd pipe, they are independent, and neither waits on a pending register write. In every other case the older instruction goes alone and the younger one moves into the older slot for the next cycle. A per-register scoreboard of 128 vector registers tracks results in flight. Even-pipe results become readable 2 cycles after issue and odd-pipe results after 4.

Fetch delivers instruction pairs over a valid/ready interface. A pair moves only on a cycle where `in_valid` and `in_ready` are both high. While `in_ready` is low, fetch must hold its pair, and the stage ignores whatever is on the input. The two pipe outputs have no back-pressure. Each carries a one-cycle valid pulse with the instruction word.

Top module: `dis_issue`

## Requirements
- R1: Reset empties both slots and clears every pending register write. Directly after reset, `even_valid` and `odd_valid` are 0 and `in_ready` is 1, and a register written just before reset can be read at once.
- R2: The instruction word is laid out as bits [3:0] class, [10:4] destination register, [17:11] first source, [24:18] second source, [25] write enable, [33:26] opaque tag. Class codes 0 to 3 go to the even pipe: 0 multiply, 1 fixed-point arithmetic, 2 logical, 3 word shift. Codes 4 to 15 go to the odd pipe: 4 permute, 5 rotate, 6 branch, 7 load/store, 8 channel, and the rest are also treated as odd.
- R3: When the older instruction is even-class and the younger is odd-class, both issue in the same cycle if they are independent and not blocked. `even_insn` then carries the older word and `odd_insn` the younger.
- R4: A pair that shares a pipe, or whose older instruction is odd-class, issues one instruction per cycle, oldest first, each on its own pipe.
- R5: If the older instruction writes (bit 25 set) and the younger reads its destination or writes the same destination, only the older one issues in that cycle.
- R6: An instruction is held while either source, or its destination when it writes, has a pending write. After an even-pipe writer issues in cycle t, that register can be used from cycle t+2. After an odd-pipe writer issues in cycle t, the register can be used from cycle t+4.
- R7: If the older instruction is blocked, nothing issues, and the younger instruction never overtakes it.
- R8: `in_ready` is high exactly when the slots are empty or every held instruction issues in the current cycle. When only the older instruction issues, `in_ready` is low for that cycle and the younger instruction occupies the older slot in the next cycle.
- R9: Input words presented while `in_ready` is low never reach either pipe.
- R10: An instruction with bit 25 clear leaves the scoreboard untouched, so a reader of its destination field issues without waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Fetch presents an instruction pair |
| in_ready | output | 1 | Stage accepts the pair this cycle; low means fetch is stalled |
| in_old | input | 34 | Older instruction of the pair |
| in_yng | input | 34 | Younger instruction of the pair |
| even_valid | output | 1 | An instruction issues to the even pipe |
| even_insn | output | 34 | Instruction word sent to the even pipe |
| odd_valid | output | 1 | An instruction issues to the odd pipe |
| odd_insn | output | 34 | Instruction word sent to the odd pipe |

## Verification
The bench targets several corner cases:
- An odd-then-even pair, where a design that paired freely would reorder execution.
- A younger reader of the older destination, where a wrong design would send a consumer alongside its producer.
- Readers placed exactly at the 2-cycle and 4-cycle boundaries, which catch a scoreboard loaded with an off-by-one count.
- A blocked older instruction with an independent odd younger, which catches any overtaking.
- A new pair driven during a stall cycle, which catches an input path that does not honour `in_ready`.
- A reset with a long write still pending, which catches a scoreboard that survives reset.

Random pairs over a small register window then mix all of these hazards against a cycle model of the rules.

// File: rtl/dis_pkg.sv
package dis_pkg;
  localparam int REG_W  = 7;
  localparam int CLS_W  = 4;
  localparam int TAG_W  = 8;
  localparam int INSN_W = TAG_W + 1 + 3 * REG_W + CLS_W;
  localparam int DST_LO = CLS_W;
  localparam int SA_LO  = DST_LO + REG_W;
  localparam int SB_LO  = SA_LO + REG_W;
  localparam int WEN_BIT = SB_LO + REG_W;

  typedef enum logic [CLS_W-1:0] {
    CL_MUL = 4'd0, CL_FXARITH = 4'd1, CL_LOGIC = 4'd2, CL_WSHIFT = 4'd3,
    CL_PERM = 4'd4, CL_ROT = 4'd5, CL_BRANCH = 4'd6, CL_LDST = 4'd7,
    CL_CHAN = 4'd8
  } cls_e;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic             wen;
    logic [REG_W-1:0] sb;
    logic [REG_W-1:0] sa;
    logic [REG_W-1:0] dst;
    logic [CLS_W-1:0] cls;
  } insn_t;

  // Class codes up to the word-shift class run on the even pipe.
  function automatic logic is_even(input logic [CLS_W-1:0] c);
    return c <= CLS_W'(CL_WSHIFT);
  endfunction

  function automatic logic reads_reg(input logic [INSN_W-1:0] w,
                                     input logic [REG_W-1:0] r);
    return (w[SA_LO +: REG_W] == r) || (w[SB_LO +: REG_W] == r);
  endfunction
endpackage

// File: rtl/dis_scoreboard.sv
module dis_scoreboard
  import dis_pkg::*;
#(
  parameter int LAT_EVEN = 2,
  parameter int LAT_ODD  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            set_en,
  input  logic [1:0]            set_odd,
  input  logic [1:0][REG_W-1:0] set_reg,
  output logic [2**REG_W-1:0]   busy
);
  localparam int NREG    = 2 ** REG_W;
  localparam int LAT_MAX = (LAT_EVEN > LAT_ODD) ? LAT_EVEN : LAT_ODD;
  localparam int CW      = (LAT_MAX > 2) ? $clog2(LAT_MAX) : 1;
  localparam logic [CW-1:0] LD_EVEN = CW'(LAT_EVEN - 1);
  localparam logic [CW-1:0] LD_ODD  = CW'(LAT_ODD - 1);

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [CW-1:0] cnt;
    logic hit0, hit1;
    assign hit0 = set_en[0] && (set_reg[0] == REG_W'(r));
    assign hit1 = set_en[1] && (set_reg[1] == REG_W'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (hit1)     cnt <= set_odd[1] ? LD_ODD : LD_EVEN;
      else if (hit0)     cnt <= set_odd[0] ? LD_ODD : LD_EVEN;
      else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign busy[r] = (cnt != '0);
  end

  AST_SET_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en[1] && LAT_ODD > 1) |=> busy[$past(set_reg[1])]); // R6
endmodule

// File: rtl/dis_pair_check.sv
module dis_pair_check
  import dis_pkg::*;
(
  input  logic                s0_v,
  input  logic [CLS_W-1:0]    s0_cls,
  input  logic [REG_W-1:0]    s0_dst,
  input  logic [REG_W-1:0]    s0_sa,
  input  logic [REG_W-1:0]    s0_sb,
  input  logic                s0_wen,
  input  logic                s1_v,
  input  logic [CLS_W-1:0]    s1_cls,
  input  logic [REG_W-1:0]    s1_dst,
  input  logic [REG_W-1:0]    s1_sa,
  input  logic [REG_W-1:0]    s1_sb,
  input  logic                s1_wen,
  input  logic [2**REG_W-1:0] busy,
  output logic                iss0,
  output logic                iss1,
  output logic                s0_even
);
  logic blk0, blk1, dep, pipes_ok;

  assign blk0 = busy[s0_sa] || busy[s0_sb] || (s0_wen && busy[s0_dst]);
  assign blk1 = busy[s1_sa] || busy[s1_sb] || (s1_wen && busy[s1_dst]);

  // Younger reads or overwrites the older destination.
  assign dep = s0_wen && ((s1_sa == s0_dst) || (s1_sb == s0_dst) ||
                          (s1_wen && (s1_dst == s0_dst)));

  assign s0_even  = is_even(s0_cls);
  assign pipes_ok = s0_even && !is_even(s1_cls);

  assign iss0 = s0_v && !blk0;
  assign iss1 = iss0 && s1_v && pipes_ok && !dep && !blk1;
endmodule

// File: rtl/dis_slot_queue.sv
module dis_slot_queue
  import dis_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  input  insn_t in_old,
  input  insn_t in_yng,
  input  logic  iss0,
  input  logic  iss1,
  output logic  in_ready,
  output insn_t s0,
  output insn_t s1,
  output logic  s0_v,
  output logic  s1_v
);
  assign in_ready = !s0_v || (iss0 && (!s1_v || iss1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_v <= 1'b0;
      s1_v <= 1'b0;
      s0   <= '0;
      s1   <= '0;
    end else if (in_valid && in_ready) begin
      s0   <= in_old;
      s1   <= in_yng;
      s0_v <= 1'b1;
      s1_v <= 1'b1;
    end else if (iss0 && s1_v && !iss1) begin
      s0   <= s1;
      s1_v <= 1'b0;
    end else if (iss0) begin
      s0_v <= 1'b0;
      s1_v <= 1'b0;
    end
  end

  AST_HOLD_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_v && !iss0) |=> (s0_v && $stable(s0))); // R7
  AST_YOUNGER_MOVES_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (iss0 && s1_v && !iss1) |=> (s0_v && !s1_v && s0 == $past(s1))); // R8
endmodule

// File: rtl/dis_issue.sv
module dis_issue
  import dis_pkg::*;
#(
  parameter int LAT_EVEN = 2,
  parameter int LAT_ODD  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] in_old,
  input  logic [INSN_W-1:0] in_yng,
  output logic              even_valid,
  output logic [INSN_W-1:0] even_insn,
  output logic              odd_valid,
  output logic [INSN_W-1:0] odd_insn
);
  localparam int NREG = 2 ** REG_W;

  insn_t s0, s1;
  logic  s0_v, s1_v, iss0, iss1, s0_even;
  logic [NREG-1:0]       busy;
  logic [1:0]            set_en, set_odd;
  logic [1:0][REG_W-1:0] set_reg;

  dis_slot_queue u_slots (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_old   (insn_t'(in_old)),
    .in_yng   (insn_t'(in_yng)),
    .iss0     (iss0),
    .iss1     (iss1),
    .in_ready (in_ready),
    .s0       (s0),
    .s1       (s1),
    .s0_v     (s0_v),
    .s1_v     (s1_v)
  );

  dis_pair_check u_check (
    .s0_v    (s0_v),
    .s0_cls  (s0.cls),
    .s0_dst  (s0.dst),
    .s0_sa   (s0.sa),
    .s0_sb   (s0.sb),
    .s0_wen  (s0.wen),
    .s1_v    (s1_v),
    .s1_cls  (s1.cls),
    .s1_dst  (s1.dst),
    .s1_sa   (s1.sa),
    .s1_sb   (s1.sb),
    .s1_wen  (s1.wen),
    .busy    (busy),
    .iss0    (iss0),
    .iss1    (iss1),
    .s0_even (s0_even)
  );

  // The younger only ever issues on the odd pipe.
  assign set_en  = {iss1 && s1.wen, iss0 && s0.wen};
  assign set_odd = {1'b1, !s0_even};
  assign set_reg = {s1.dst, s0.dst};

  dis_scoreboard #(.LAT_EVEN(LAT_EVEN), .LAT_ODD(LAT_ODD)) u_sb (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (set_en),
    .set_odd (set_odd),
    .set_reg (set_reg),
    .busy    (busy)
  );

  assign even_valid = iss0 && s0_even;
  assign even_insn  = s0;
  assign odd_valid  = (iss0 && !s0_even) || iss1;
  assign odd_insn   = iss1 ? s1 : s0;

  AST_PAIR_NO_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (even_valid && odd_valid && even_insn[WEN_BIT])
      |-> !reads_reg(odd_insn, even_insn[DST_LO +: REG_W])); // R5
  AST_EVEN_RESULT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (even_valid && even_insn[WEN_BIT] && LAT_EVEN > 1)
      |=> !(even_valid && reads_reg(even_insn, $past(even_insn[DST_LO +: REG_W])))
       && !(odd_valid && reads_reg(odd_insn, $past(even_insn[DST_LO +: REG_W])))); // R6
endmodule

// File: tb/sim_dis_issue.sv
module sim_dis_issue;
  localparam int W = 34;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_old = '0, in_yng = '0;
  logic         in_ready, even_valid, odd_valid;
  logic [W-1:0] even_insn, odd_insn;

  always #4 clk = ~clk;

  dis_issue u0 (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
    .in_old (in_old), .in_yng (in_yng), .even_valid (even_valid),
    .even_insn (even_insn), .odd_valid (odd_valid), .odd_insn (odd_insn)
  );

  int errs = 0, checks = 0, cyc = 0;
  string cur_req = "R2";
  int rdy [128];
  int t_ev [256];
  int t_od [256];
  logic [W-1:0] m0 = '0, m1 = '0;
  bit mv0 = 0, mv1 = 0, acc = 0;

  function automatic logic [W-1:0] mk(int c, int d, int a, int b, int w, int t);
    return {8'(t), 1'(w), 7'(b), 7'(a), 7'(d), 4'(c)};
  endfunction
  function automatic bit evp(logic [W-1:0] x);
    return x[3:0] < 4;
  endfunction
  function automatic bit blk(logic [W-1:0] x);
    return rdy[x[17:11]] > cyc || rdy[x[24:18]] > cyc || (x[25] && rdy[x[10:4]] > cyc);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 128; i++) rdy[i] = 0;
    mv0 = 0; mv1 = 0;
  endtask

  task automatic step(bit v, logic [W-1:0] o, logic [W-1:0] y);
    bit e0, e1, dep, xr, xe, xo;
    logic [W-1:0] xoi;
    @(negedge clk);
    in_valid = v; in_old = o; in_yng = y;
    #1;
    e0  = mv0 && !blk(m0);
    dep = m0[25] && (m1[17:11] == m0[10:4] || m1[24:18] == m0[10:4] ||
                     (m1[25] && m1[10:4] == m0[10:4]));
    e1  = e0 && mv1 && evp(m0) && !evp(m1) && !dep && !blk(m1);
    xe  = e0 && evp(m0);
    xo  = (e0 && !evp(m0)) || e1;
    xoi = e1 ? m1 : m0;
    xr  = !mv0 || (e0 && (!mv1 || e1));
    chk(in_ready === xr, "R8", "in_ready", W'(in_ready), W'(xr));
    chk(even_valid === xe, cur_req, "even_valid", W'(even_valid), W'(xe));
    chk(odd_valid === xo, cur_req, "odd_valid", W'(odd_valid), W'(xo));
    if (xe && even_valid) chk(even_insn === m0, cur_req, "even_insn", even_insn, m0);
    if (xo && odd_valid) chk(odd_insn === xoi, cur_req, "odd_insn", odd_insn, xoi);
    if (even_valid) t_ev[even_insn[33:26]] = cyc;
    if (odd_valid) t_od[odd_insn[33:26]] = cyc;
    if (e0 && m0[25]) rdy[m0[10:4]] = cyc + (evp(m0) ? 2 : 4);
    if (e1 && m1[25]) rdy[m1[10:4]] = cyc + 4;
    acc = v && xr;
    if (acc) begin
      m0 = o; m1 = y; mv0 = 1; mv1 = 1;
    end else if (e0 && mv1 && !e1) begin
      m0 = m1; mv1 = 0;
    end else if (e0) begin
      mv0 = 0; mv1 = 0;
    end
    cyc++;
  endtask

  task automatic send(logic [W-1:0] o, logic [W-1:0] y, output int tac);
    do step(1, o, y); while (!acc);
    tac = cyc - 1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, '0, '0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    model_reset();
    #1;
    chk(in_ready === 1'b1, "R1", "in_ready after reset", W'(in_ready), W'(1));
    chk(even_valid === 1'b0, "R1", "even_valid after reset", W'(even_valid), W'(0));
    chk(odd_valid === 1'b0, "R1", "odd_valid after reset", W'(odd_valid), W'(0));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int ta, tb;
    for (int i = 0; i < 256; i++) begin t_ev[i] = -1; t_od[i] = -1; end
    void'($urandom(32'd2024));
    model_reset();
    do_reset();

    // R2: class code selects pipe
    cur_req = "R2";
    for (int c = 0; c < 9; c++) begin
      idle(5);
      send(mk(c, 20, 21, 22, 0, 80 + c), mk(2, 23, 24, 25, 0, 100 + c), ta);
      idle(3);
      chk((c < 4) ? (t_ev[80 + c] == ta + 1) : (t_od[80 + c] == ta + 1), "R2",
          "pipe by class", W'(c), W'(c));
    end

    // R3: even then odd, independent -> same cycle
    cur_req = "R3"; idle(5);
    send(mk(1, 1, 2, 3, 1, 10), mk(5, 4, 5, 6, 1, 11), ta); idle(5);
    chk(t_ev[10] == ta + 1 && t_od[11] == ta + 1, "R3", "dual issue cycle",
        W'(t_od[11] - t_ev[10]), W'(0));

    // R4 and R9: odd then even serialises; pair offered during stall ignored
    cur_req = "R4"; idle(5);
    send(mk(6, 1, 2, 3, 0, 20), mk(0, 4, 5, 6, 0, 21), ta);
    step(1, mk(0, 7, 8, 9, 0, 50), mk(4, 10, 11, 12, 0, 51));
    step(0, '0, '0); idle(5);
    chk(t_ev[21] - t_od[20] == 1, "R4", "older odd first", W'(t_ev[21] - t_od[20]), W'(1));
    chk(t_ev[50] == -1 && t_od[51] == -1, "R9", "stalled input dropped",
        W'(t_ev[50] + 1), W'(0));
    idle(2);
    send(mk(2, 1, 2, 3, 0, 22), mk(3, 4, 5, 6, 0, 23), ta); idle(4);
    chk(t_ev[23] - t_ev[22] == 1, "R4", "same pipe serial", W'(t_ev[23] - t_ev[22]), W'(1));

    // R5: younger reads older destination
    cur_req = "R5"; idle(5);
    send(mk(1, 3, 1, 2, 1, 30), mk(4, 9, 3, 8, 1, 31), ta); idle(6);
    chk(t_ev[30] == ta + 1 && t_od[31] == ta + 3, "R5", "raw inside pair",
        W'(t_od[31] - t_ev[30]), W'(2));

    // R6: latency boundaries for even and odd writers
    cur_req = "R6"; idle(5);
    send(mk(0, 5, 1, 2, 1, 40), mk(7, 6, 1, 2, 1, 41), ta);
    send(mk(1, 7, 5, 2, 1, 42), mk(8, 8, 3, 4, 0, 43), tb); idle(6);
    chk(t_ev[42] - t_ev[40] == 2, "R6", "even latency", W'(t_ev[42] - t_ev[40]), W'(2));
    idle(5);
    send(mk(0, 9, 1, 2, 1, 44), mk(7, 12, 1, 2, 1, 45), ta);
    send(mk(1, 13, 12, 2, 1, 46), mk(8, 14, 3, 4, 0, 47), tb); idle(8);
    chk(t_ev[46] - t_od[45] == 4, "R6", "odd latency", W'(t_ev[46] - t_od[45]), W'(4));

    // R7: blocked older holds the younger back
    cur_req = "R7"; idle(5);
    send(mk(5, 12, 1, 2, 1, 60), mk(1, 15, 1, 2, 0, 61), ta);
    send(mk(2, 16, 12, 3, 0, 62), mk(4, 17, 3, 4, 0, 63), tb); idle(8);
    chk(t_ev[62] - t_od[60] == 4 && t_od[63] == t_ev[62], "R7", "no overtaking",
        W'(t_od[63] - t_od[60]), W'(4));

    // R10: non-writing instruction leaves scoreboard alone
    cur_req = "R10"; idle(5);
    send(mk(1, 18, 1, 2, 0, 64), mk(4, 19, 3, 4, 0, 65), ta);
    send(mk(0, 20, 18, 2, 1, 66), mk(4, 21, 19, 4, 0, 67), tb); idle(5);
    chk(t_ev[66] - t_ev[64] == 1, "R10", "no wait on wen=0", W'(t_ev[66] - t_ev[64]), W'(1));

    // R1: reset clears a pending odd write
    cur_req = "R1"; idle(5);
    send(mk(7, 9, 1, 2, 1, 70), mk(6, 2, 1, 3, 0, 71), ta);
    step(0, '0, '0);
    do_reset();
    send(mk(1, 22, 9, 9, 1, 72), mk(4, 23, 9, 1, 0, 73), ta); idle(3);
    chk(t_ev[72] == ta + 1, "R1", "scoreboard cleared", W'(t_ev[72] - ta), W'(1));

    // Random mix over a small register window
    cur_req = "R2";
    idle(5);
    for (int k = 0; k < 3000; k++) begin
      logic [W-1:0] a, b;
      a = mk($urandom % 9, $urandom % 8, $urandom % 8, $urandom % 8,
             ($urandom % 4) != 0, 128 + (k % 128));
      b = mk($urandom % 9, $urandom % 8, $urandom % 8, $urandom % 8,
             ($urandom % 4) != 0, 128 + ((k + 64) % 128));
      step(($urandom % 4) != 0, a, b);
    end
    idle(6);
    finish_run();
  end
endmodule